// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces operand addresses for indirect memory accesses. It keeps a bank of index pointers, a bank of modify values and a bank of buffer lengths. Each access request names one pointer and, separately, one modify register. The block emits the selected pointer as the address and then advances that pointer by the modify amount.

A nonzero length attached to a pointer confines the pointer to a circular buffer. The buffer starts at the pointer value rounded down to a multiple of the smallest power of two that is at least the length. Any update that leaves that window is pulled back by adding or subtracting the length. A zero length gives plain linear stepping, modulo the address width.

A per-request mode flag can reverse the bit order of the emitted address, which suits FFT-style reordering. The stored pointer always keeps its normal updated value. Software-style register writes and a combinational read port load and inspect the banks.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, every index, modify and length register reads 0, `addr_vld_o` is low and `addr_o` is 0.
- R2: A write with `wr_en_i` high stores `wr_data_i` into the register named by `wr_idx_i` in the bank named by `wr_kind_i` (0 = index, 1 = modify, 2 = length). `rd_data_o` shows, in the same cycle, the register named by `rd_kind_i`/`rd_idx_i`; kind 3 reads 0.
- R3: A request (`req_i` high at a clock edge) makes `addr_vld_o` high in the following cycle, and `addr_o` then holds the value of the pointer named by `ptr_sel_i` before its update. Each request yields exactly one valid address, in request order.
- R4: With the selected pointer's length at 0, the pointer becomes pointer + modify, where modify is a 14-bit two's complement value and the sum wraps modulo 2^14. The modify register is chosen by `mod_sel_i`, independently of the pointer.
- R5: With a nonzero length L and |modify| <= L, the updated pointer stays in [B, B+L). B is the pointer with its low bits cleared, and the number of cleared bits is the log2 of the smallest power of two >= L. A sum at or above B+L has L subtracted, and a sum below B has L added.
- R6: When `bitrev_i` is high with a request, `addr_o` is the pointer with bit k moved to bit 13-k. The stored pointer still receives its normal update.
- R7: A write to the index register that a request uses in the same cycle wins: the address is the old pointer, and the pointer then holds the written value. A write to a different index register in that cycle takes effect alongside the update.
- R8: Cycles without a request leave all pointers unchanged and keep `addr_vld_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Bank to write: 0 index, 1 modify, 2 length |
| wr_idx_i | input | 2 | Register number within the bank |
| wr_data_i | input | 14 | Write data |
| rd_kind_i | input | 2 | Bank to read (3 reads zero) |
| rd_idx_i | input | 2 | Register number to read |
| rd_data_o | output | 14 | Combinational read data |
| req_i | input | 1 | Access request |
| ptr_sel_i | input | 2 | Pointer used by the request |
| mod_sel_i | input | 2 | Modify register used by the request |
| bitrev_i | input | 1 | Emit the address bit-reversed |
| addr_o | output | 14 | Generated address, registered |
| addr_vld_o | output | 1 | Address valid, one cycle per request |

## Verification
A pointer that is updated wrongly stays hidden until that pointer is used again or read back. The next request on that pointer then shows a wrong `addr_o` one cycle after the edge. The bench therefore chains several requests on each pointer, so a bad wrap correction or a bad modify selection is caught on the very next address. Readbacks after bit-reversed accesses and after colliding writes show, in the same cycle, whether the stored state diverged from what the address output implied.

// File: rtl/cag_pkg.sv
package cag_pkg;
  typedef enum logic [1:0] {
    KIND_IDX  = 2'd0,
    KIND_MOD  = 2'd1,
    KIND_LEN  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/cag_regfile.sv
module cag_regfile
  import cag_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  reg_kind_e       wr_kind_i,
  input  logic [SW-1:0]   wr_idx_i,
  input  logic [AW-1:0]   wr_data_i,
  input  logic            upd_en_i,
  input  logic [SW-1:0]   upd_idx_i,
  input  logic [AW-1:0]   upd_val_i,
  input  reg_kind_e       rd_kind_i,
  input  logic [SW-1:0]   rd_idx_i,
  output logic [AW-1:0]   rd_data_o,
  output logic [AW-1:0]   idx_o [NREG],
  output logic [AW-1:0]   mod_o [NREG],
  output logic [AW-1:0]   len_o [NREG]
);

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    logic wr_hit_idx, wr_hit_mod, wr_hit_len;
    assign wr_hit_idx = wr_en_i && (wr_kind_i == KIND_IDX) && (wr_idx_i == SW'(g));
    assign wr_hit_mod = wr_en_i && (wr_kind_i == KIND_MOD) && (wr_idx_i == SW'(g));
    assign wr_hit_len = wr_en_i && (wr_kind_i == KIND_LEN) && (wr_idx_i == SW'(g));

    // register write has priority over post-modify
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               idx_o[g] <= '0;
      else if (wr_hit_idx)                       idx_o[g] <= wr_data_i;
      else if (upd_en_i && upd_idx_i == SW'(g))  idx_o[g] <= upd_val_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         mod_o[g] <= '0;
      else if (wr_hit_mod) mod_o[g] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         len_o[g] <= '0;
      else if (wr_hit_len) len_o[g] <= wr_data_i;
    end
  end

  always_comb begin
    unique case (rd_kind_i)
      KIND_IDX: rd_data_o = idx_o[rd_idx_i];
      KIND_MOD: rd_data_o = mod_o[rd_idx_i];
      KIND_LEN: rd_data_o = len_o[rd_idx_i];
      default:  rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/cag_wrap.sv
module cag_wrap #(
  parameter int AW  = 14,
  localparam int EW = AW + 2
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] mod_i,
  input  logic [AW-1:0] len_i,
  output logic [AW-1:0] nxt_o
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0]        mask;
  logic signed [EW-1:0] sum, off, len_s;

  always_comb begin
    // smear len-1 rightwards: gives (power of two >= len) - 1
    mask = len_i - ONE;
    for (int s = 1; s < AW; s = s * 2) mask = mask | (mask >> s);
    sum   = $signed({2'b00, ptr_i}) + $signed({{2{mod_i[AW-1]}}, mod_i});
    off   = sum - $signed({2'b00, ptr_i & ~mask});
    len_s = $signed({2'b00, len_i});
    if (len_i == '0)         nxt_o = sum[AW-1:0];
    else if (off >= len_s)   nxt_o = sum[AW-1:0] - len_i;
    else if (off[EW-1])      nxt_o = sum[AW-1:0] + len_i;
    else                     nxt_o = sum[AW-1:0];
  end

endmodule

// File: rtl/cag_bitrev.sv
module cag_bitrev #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] in_i,
  output logic [AW-1:0] out_o
);

  for (genvar g = 0; g < AW; g++) begin : g_rev
    assign out_o[g] = in_i[AW-1-g];
  end

endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cag_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_kind_i,
  input  logic [SW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [1:0]    rd_kind_i,
  input  logic [SW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o,
  input  logic          req_i,
  input  logic [SW-1:0] ptr_sel_i,
  input  logic [SW-1:0] mod_sel_i,
  input  logic          bitrev_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_vld_o
);

  logic [AW-1:0] idx_arr [NREG];
  logic [AW-1:0] mod_arr [NREG];
  logic [AW-1:0] len_arr [NREG];
  logic [AW-1:0] cur, mod_cur, len_cur, nxt, rev;

  cag_regfile #(.AW(AW), .NREG(NREG)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_kind_i (reg_kind_e'(wr_kind_i)),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .upd_en_i  (req_i),
    .upd_idx_i (ptr_sel_i),
    .upd_val_i (nxt),
    .rd_kind_i (reg_kind_e'(rd_kind_i)),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .idx_o     (idx_arr),
    .mod_o     (mod_arr),
    .len_o     (len_arr)
  );

  assign cur     = idx_arr[ptr_sel_i];
  assign mod_cur = mod_arr[mod_sel_i];
  assign len_cur = len_arr[ptr_sel_i];

  cag_wrap #(.AW(AW)) u_wrap (
    .ptr_i (cur),
    .mod_i (mod_cur),
    .len_i (len_cur),
    .nxt_o (nxt)
  );

  cag_bitrev #(.AW(AW)) u_rev (
    .in_i  (cur),
    .out_o (rev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
    end else begin
      addr_vld_o <= req_i;
      if (req_i) addr_o <= bitrev_i ? rev : cur;
    end
  end

  // ---------------- assertions ----------------
  logic          same_wr, idx_wr;
  logic [AW-1:0] dlt;
  assign idx_wr  = wr_en_i && (wr_kind_i == 2'(KIND_IDX));
  assign same_wr = idx_wr && (wr_idx_i == ptr_sel_i);
  assign dlt     = nxt - cur - mod_cur;

  a_r3_vld_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> addr_vld_o);

  a_r8_no_vld_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !addr_vld_o);

  a_r4_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && len_cur == '0 && !same_wr) |=>
      idx_arr[$past(ptr_sel_i)] == $past(cur + mod_cur));

  a_r5_wrap_by_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && len_cur != '0) |-> (dlt == '0 || dlt == len_cur || dlt == ('0 - len_cur)));

  a_r6_same_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> $countones(addr_o) == $countones($past(cur)));

  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr |=> idx_arr[$past(wr_idx_i)] == $past(wr_data_i));

endmodule

// File: tb/sim_circ_addr_gen.sv
module sim_circ_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 14;
  localparam int NREG = 4;
  localparam int SW   = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_kind_i = '0;
  logic [SW-1:0] wr_idx_i = '0;
  logic [AW-1:0] wr_data_i = '0;
  logic [1:0]    rd_kind_i = '0;
  logic [SW-1:0] rd_idx_i = '0;
  logic [AW-1:0] rd_data_o;
  logic          req_i = 1'b0;
  logic [SW-1:0] ptr_sel_i = '0;
  logic [SW-1:0] mod_sel_i = '0;
  logic          bitrev_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          addr_vld_o;

  circ_addr_gen #(.AW(AW), .NREG(NREG)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .rd_kind_i(rd_kind_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .req_i(req_i), .ptr_sel_i(ptr_sel_i), .mod_sel_i(mod_sel_i), .bitrev_i(bitrev_i),
    .addr_o(addr_o), .addr_vld_o(addr_vld_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] m_idx [NREG];
  logic [AW-1:0] m_mod [NREG];
  logic [AW-1:0] m_len [NREG];
  logic [AW-1:0] exp_q [$];
  string         tag_q [$];
  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] p, input logic [AW-1:0] m,
                                              input logic [AW-1:0] l);
    int pw, base, s, mv;
    mv = m[AW-1] ? int'(m) - (1 << AW) : int'(m);
    if (l == '0) return AW'(int'(p) + mv);
    pw = 1;
    while (pw < int'(l)) pw = pw * 2;
    base = int'(p) - (int'(p) % pw);
    s = int'(p) + mv;
    if (s >= base + int'(l)) s = s - int'(l);
    else if (s < base)       s = s + int'(l);
    return AW'(s);
  endfunction

  function automatic logic [AW-1:0] ref_rev(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int k = 0; k < AW; k++) r[AW-1-k] = v[k];
    return r;
  endfunction

  // monitor: pops expected addresses as valid addresses appear
  always @(negedge clk) begin
    #1;
    if (rst_ni && addr_vld_o) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 unexpected valid actual=%h expected=none", addr_o);
      end else begin
        chk(tag_q.pop_front(), addr_o, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] kind, input int idx, input logic [AW-1:0] data);
    @(negedge clk);
    req_i = 1'b0; wr_en_i = 1'b1; wr_kind_i = kind; wr_idx_i = SW'(idx); wr_data_i = data;
    if (kind == 2'd0) m_idx[idx] = data;
    if (kind == 2'd1) m_mod[idx] = data;
    if (kind == 2'd2) m_len[idx] = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic acc(input int p, input int m, input logic br, input string tag);
    @(negedge clk);
    wr_en_i = 1'b0; req_i = 1'b1; ptr_sel_i = SW'(p); mod_sel_i = SW'(m); bitrev_i = br;
    exp_q.push_back(br ? ref_rev(m_idx[p]) : m_idx[p]);
    tag_q.push_back(tag);
    m_idx[p] = ref_next(m_idx[p], m_mod[m], m_len[p]);
  endtask

  task automatic acc_wr(input int p, input int m, input int widx, input logic [AW-1:0] wdata,
                        input string tag);
    @(negedge clk);
    req_i = 1'b1; ptr_sel_i = SW'(p); mod_sel_i = SW'(m); bitrev_i = 1'b0;
    wr_en_i = 1'b1; wr_kind_i = 2'd0; wr_idx_i = SW'(widx); wr_data_i = wdata;
    exp_q.push_back(m_idx[p]);
    tag_q.push_back(tag);
    m_idx[p] = ref_next(m_idx[p], m_mod[m], m_len[p]);
    m_idx[widx] = wdata;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_i = 1'b0; wr_en_i = 1'b0; bitrev_i = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] kind, input int idx, input logic [AW-1:0] exp,
                    input string tag);
    @(negedge clk);
    req_i = 1'b0; wr_en_i = 1'b0; rd_kind_i = kind; rd_idx_i = SW'(idx);
    #2;
    chk(tag, rd_data_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin m_idx[i] = '0; m_mod[i] = '0; m_len[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 vld", AW'(addr_vld_o), '0);
    chk("R1 addr", addr_o, '0);
    rst_ni = 1'b1;
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < NREG; i++) rd(k[1:0], i, '0, "R1 reg");

    // R2: write / readback, kind 3 reads zero
    wr(2'd0, 0, 14'h0010); wr(2'd1, 0, 14'h0003);
    wr(2'd0, 1, 14'h0002); wr(2'd1, 1, 14'h3FFB);
    wr(2'd0, 2, 14'h0023); wr(2'd2, 2, 14'd10);
    wr(2'd1, 2, 14'h0003); wr(2'd1, 3, 14'h3FFC);
    wr(2'd0, 3, 14'h0105); wr(2'd2, 3, 14'd8);
    rd(2'd1, 1, 14'h3FFB, "R2 mod1");
    rd(2'd2, 2, 14'd10, "R2 len2");
    rd(2'd0, 3, 14'h0105, "R2 idx3");
    rd(2'd3, 2, '0, "R2 kind3");

    // R3/R4: linear, positive and negative modify, back-to-back
    acc(0, 0, 1'b0, "R3 lin p0");
    acc(0, 0, 1'b0, "R4 lin p0");
    acc(0, 0, 1'b0, "R4 lin p0");
    acc(1, 1, 1'b0, "R4 neg p1");
    acc(1, 1, 1'b0, "R4 neg wrap 2^14");
    acc(0, 1, 1'b0, "R4 mod indep");
    acc(0, 0, 1'b0, "R4 mod indep");
    idle(2);
    chk("R8 vld low", AW'(addr_vld_o), '0);

    // R5: circular buffer, length 10 and length 8, both directions
    for (int i = 0; i < 5; i++) acc(2, 2, 1'b0, "R5 up L10");
    for (int i = 0; i < 5; i++) acc(2, 3, 1'b0, "R5 down L10");
    for (int i = 0; i < 4; i++) acc(3, 2, 1'b0, "R5 up L8");
    for (int i = 0; i < 4; i++) acc(3, 3, 1'b0, "R5 down L8");
    idle(2);
    rd(2'd0, 2, m_idx[2], "R5 idx2 state");
    rd(2'd0, 3, m_idx[3], "R5 idx3 state");

    // R6: bit reversal on output only
    wr(2'd0, 0, 14'h0001);
    acc(0, 0, 1'b1, "R6 rev");
    acc(0, 0, 1'b1, "R6 rev");
    acc(2, 2, 1'b1, "R6 rev circ");
    idle(2);
    rd(2'd0, 0, m_idx[0], "R6 stored normal");
    acc(0, 0, 1'b0, "R6 normal after rev");

    // R7: write collisions
    acc_wr(1, 0, 1, 14'h0ABC, "R7 old addr");
    acc(1, 0, 1'b0, "R7 written used");
    acc_wr(1, 0, 2, 14'h0021, "R7 other ptr");
    idle(2);
    rd(2'd0, 1, m_idx[1], "R7 upd ptr1");
    rd(2'd0, 2, 14'h0021, "R7 wr ptr2");

    // R8: idle cycles keep pointers
    idle(5);
    chk("R8 vld low", AW'(addr_vld_o), '0);
    for (int i = 0; i < NREG; i++) rd(2'd0, i, m_idx[i], "R8 hold");

    idle(3);
    chk("R3 pending", AW'(exp_q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule